// File: doc/BRIEF.md
# Burst Transfer Bridge: Local DMA Word to Byte-Serial Target Output

This block is a clocked controller for the send direction of a byte-wide peripheral bus operating as target, fed by a DMA engine in block (burst) mode. A single start pulse makes it ask the DMA engine for service. The engine then delivers 32-bit words through an acknowledge / ready / transfer-complete handshake. Each word is captured into a shift register. The word then leaves as four bytes, least significant byte first, through a four-phase request/acknowledge exchange with the initiator.

The DMA engine marks the final word by holding its last-transfer level high together with its acknowledge and strobe. The controller reads that level only on the rising edge of the strobe, and reads its own word-empty flag only on the falling edge of the initiator acknowledge. Glitches on either level between those sample points therefore have no effect. All handshake inputs from the two foreign domains pass through two-flop synchronizers, and edges are taken from the synchronized copies.

Top module: `tsend_xfer_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dreq_o`, `ready_o` and `req_o` are low and `sdata_o` is zero after that edge.
- R2: A `start_i` pulse seen while idle sets `dreq_o` after that edge. A `start_i` pulse seen while a transfer is in progress has no effect on any output.
- R3: While waiting for the DMA engine, `ready_o` rises once synchronized acknowledge is high. It falls on the edge where the synchronized strobe is seen rising, and `data_i` is captured on that same edge.
- R4: `req_o` rises only when the synchronized acknowledge and strobe are both low after a capture. `ready_o` and `req_o` are never high together.
- R5: Bytes leave on `sdata_o` in the order `data_i[7:0]`, `[15:8]`, `[23:16]`, `[31:24]`. Each byte is valid from before `req_o` rises until the acknowledge rises, and `sdata_o` does not change while `req_o` stays high.
- R6: A synchronized rising acknowledge drops `req_o` and shifts the next byte onto `sdata_o`. A synchronized falling acknowledge raises `req_o` again for the second, third and fourth bytes.
- R7: The word completes on the fourth acknowledge falling edge: `req_o` stays low, and `ready_o` is raised again once acknowledge is seen high, unless the word was the final one.
- R8: The last-transfer level is sampled only at the strobe rising edge. After the fourth byte of a word marked final, `dreq_o` falls and the block returns to idle. Pulses on that level at any other time have no effect.
- R9: Input synchronization costs two cycles. An acknowledge rising while the block waits shows up as `ready_o` high three clock edges after the input changed, and an initiator acknowledge edge likewise changes `req_o` three edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst transfer (synchronous pulse) |
| dack_i | input | 1 | DMA acknowledge (asynchronous) |
| dtc_i | input | 1 | DMA transfer-complete strobe, word valid while high (asynchronous) |
| done_i | input | 1 | DMA last-transfer level, valid with the strobe (asynchronous) |
| data_i | input | DATA_W | DMA word, held stable around the strobe |
| ack_i | input | 1 | Initiator byte acknowledge (asynchronous) |
| dreq_o | output | 1 | Service request to the DMA engine |
| ready_o | output | 1 | Ready to accept a word |
| req_o | output | 1 | Byte request to the initiator |
| sdata_o | output | BYTE_W | Byte-wide output data |

## Verification
A wrong handshake state shows within one cycle as a mismatch on `dreq_o`, `ready_o` or `req_o` against the bench's cycle model. For example, a request raised while the strobe is still high, or a ready that never falls. A corrupted byte counter or shift register surfaces at the next initiator acknowledge: the wrong byte, or a fifth or missing request at the word boundary. A misplaced last-transfer sample shows when `dreq_o` falls one word early or fails to fall after the final word, including under pulses on the last-transfer input in mid-word.

// File: rtl/tsend_xfer_ctrl.sv
module tsend_xfer_ctrl #(
  parameter int DATA_W      = 32,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dack_i,
  input  logic              dtc_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic              dreq_o,
  output logic              ready_o,
  output logic              req_o,
  output logic [BYTE_W-1:0] sdata_o
);
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NBYTES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_ACKN, S_WAIT_STROBE, S_WAIT_BUSFREE, S_REQ_HI, S_REQ_LO
  } state_t;

  state_t state;

  logic [SYNC_STAGES-1:0] dack_p, done_p;
  logic [SYNC_STAGES:0]   dtc_p, ack_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      dack_p <= '0;
      done_p <= '0;
      dtc_p  <= '0;
      ack_p  <= '0;
    end else begin
      dack_p <= {dack_p[SYNC_STAGES-2:0], dack_i};
      done_p <= {done_p[SYNC_STAGES-2:0], done_i};
      dtc_p  <= {dtc_p[SYNC_STAGES-1:0], dtc_i};
      ack_p  <= {ack_p[SYNC_STAGES-1:0], ack_i};
    end
  end

  logic dack_s, done_s, dtc_s, ack_s;
  logic dtc_rise, ack_rise, ack_fall;

  assign dack_s   = dack_p[SYNC_STAGES-1];
  assign done_s   = done_p[SYNC_STAGES-1];
  assign dtc_s    = dtc_p[SYNC_STAGES-1];
  assign ack_s    = ack_p[SYNC_STAGES-1];
  assign dtc_rise = dtc_s & ~dtc_p[SYNC_STAGES];
  assign ack_rise = ack_s & ~ack_p[SYNC_STAGES];
  assign ack_fall = ~ack_s & ack_p[SYNC_STAGES];

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              empty_q;
  logic              last_q;

  assign sdata_o = shreg[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      dreq_o  <= 1'b0;
      ready_o <= 1'b0;
      req_o   <= 1'b0;
      shreg   <= '0;
      cnt     <= '0;
      empty_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          dreq_o <= 1'b1;
          state  <= S_WAIT_ACKN;
        end
        S_WAIT_ACKN: if (dack_s) begin
          ready_o <= 1'b1;
          state   <= S_WAIT_STROBE;
        end
        S_WAIT_STROBE: if (dtc_rise) begin
          shreg   <= data_i;
          last_q  <= done_s;
          ready_o <= 1'b0;
          cnt     <= '0;
          empty_q <= 1'b0;
          state   <= S_WAIT_BUSFREE;
        end
        S_WAIT_BUSFREE: if (!dack_s && !dtc_s) begin
          req_o <= 1'b1;
          state <= S_REQ_HI;
        end
        S_REQ_HI: if (ack_rise) begin
          shreg   <= shreg >> BYTE_W;
          cnt     <= cnt + 1'b1;
          empty_q <= (cnt == CNT_LAST);
          req_o   <= 1'b0;
          state   <= S_REQ_LO;
        end
        S_REQ_LO: if (ack_fall) begin
          if (empty_q) begin
            if (last_q) begin
              dreq_o <= 1'b0;
              state  <= S_IDLE;
            end else begin
              state <= S_WAIT_ACKN;
            end
          end else begin
            req_o <= 1'b1;
            state <= S_REQ_HI;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsend_xfer_chk.sv
module tsend_xfer_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          dreq,
  input logic          ready,
  input logic          req,
  input logic [BW-1:0] sdata,
  input logic          ack_s,
  input logic          dtc_s
);
  // R4
  ready_req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ready && req));

  // R5
  byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req && $past(req)) |-> $stable(sdata));

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> $past(ack_s));

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(dtc_s));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !dreq |-> (!ready && !req));
endmodule

bind tsend_xfer_ctrl tsend_xfer_chk #(.BW(BYTE_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .dreq  (dreq_o),
  .ready (ready_o),
  .req   (req_o),
  .sdata (sdata_o),
  .ack_s (ack_s),
  .dtc_s (dtc_s)
);

// File: tb/tsend_xfer_ctrl_bench.sv
module tsend_xfer_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, dack_i = 1'b0, dtc_i = 1'b0, done_i = 1'b0, ack_i = 1'b0;
  logic [31:0] data_i = '0;
  logic dreq_o, ready_o, req_o;
  logic [7:0] sdata_o;

  always #5 clk = ~clk;

  tsend_xfer_ctrl u_tsend_xfer_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .dack_i(dack_i), .dtc_i(dtc_i),
    .done_i(done_i), .data_i(data_i), .ack_i(ack_i), .dreq_o(dreq_o),
    .ready_o(ready_o), .req_o(req_o), .sdata_o(sdata_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] words [0:7];
  logic [7:0]  exp_bytes [$];
  int          rx_count;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: delayed input copies and a byte queue
  int   m_st;
  bit   m_dreq, m_ready, m_req, m_last;
  bit   dk1, dk2, dt1, dt2, dt3, dn1, dn2, ak1, ak2, ak3;
  byte  m_q [$];

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_dreq = 0; m_ready = 0; m_req = 0; m_last = 0;
      m_q.delete();
      {dk1, dk2, dt1, dt2, dt3, dn1, dn2, ak1, ak2, ak3} = '0;
    end else begin
      case (m_st)
        0: if (start_i) begin m_dreq = 1; m_st = 1; end
        1: if (dk2) begin m_ready = 1; m_st = 2; end
        2: if (dt2 && !dt3) begin
             for (int b = 0; b < 4; b++) m_q.push_back(data_i[8*b +: 8]);
             m_last = dn2; m_ready = 0; m_st = 3;
           end
        3: if (!dk2 && !dt2) begin m_req = 1; m_st = 4; end
        4: if (ak2 && !ak3) begin void'(m_q.pop_front()); m_req = 0; m_st = 5; end
        5: if (!ak2 && ak3) begin
             if (m_q.size() == 0) begin
               if (m_last) begin m_dreq = 0; m_st = 0; end
               else m_st = 1;
             end else begin m_req = 1; m_st = 4; end
           end
        default: m_st = 0;
      endcase
      dk2 = dk1; dk1 = dack_i;
      dt3 = dt2; dt2 = dt1; dt1 = dtc_i;
      dn2 = dn1; dn1 = done_i;
      ak3 = ak2; ak2 = ak1; ak1 = ack_i;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic [7:0] m_sd;
      m_sd = (m_q.size() != 0) ? m_q[0] : 8'h00;
      chk(dreq_o == m_dreq && ready_o == m_ready && req_o == m_req && sdata_o == m_sd,
          "R2 R3 R4 R6 R7 R8 cycle model {dreq,ready,req,sdata}",
          {dreq_o, ready_o, req_o, sdata_o}, {m_dreq, m_ready, m_req, m_sd});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic dma_run(input int n);
    while (!dreq_o) @(negedge clk);
    for (int w = 0; w < n; w++) begin
      @(negedge clk) dack_i = 1;
      if (w == 0) begin
        int lat = 0;
        while (!ready_o) begin @(negedge clk); lat++; end
        chk(lat == 3, "R9 ready latency after acknowledge", lat, 3);
      end else begin
        while (ready_o) @(negedge clk);
        while (!ready_o) @(negedge clk);
      end
      @(negedge clk);
      data_i = words[w]; dtc_i = 1; done_i = (w == n - 1);
      @(negedge clk);
      dtc_i = 0; dack_i = 0; done_i = 0;
    end
  endtask

  task automatic initiator(input int nbytes, input int mode);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] e;
      while (!req_o) @(negedge clk);
      repeat ((k * mode) % 4) @(negedge clk);
      e = exp_bytes.pop_front();
      chk(sdata_o == e, "R5 byte order at request", sdata_o, e);
      rx_count++;
      ack_i = 1;
      repeat (3) @(negedge clk);
      chk(req_o == 0, "R6 request drop 3 edges after ack rise", req_o, 0);
      repeat (k % 3) @(negedge clk);
      ack_i = 0;
      repeat (3) @(negedge clk);
      if (k % 4 == 3)
        chk(req_o == 0, "R7 no request after fourth byte", req_o, 0);
      else
        chk(req_o == 1, "R6 request for next byte after ack fall", req_o, 1);
    end
  endtask

  task automatic glitch_done();
    while (!req_o) @(negedge clk);
    @(negedge clk) done_i = 1;
    repeat (2) @(negedge clk);
    done_i = 0;
    @(negedge clk) done_i = 1;
    @(negedge clk) done_i = 0;
  endtask

  task automatic late_start();
    while (!req_o) @(negedge clk);
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic run_case(input int n, input int mode, input bit glitch, input bit midstart);
    exp_bytes.delete();
    rx_count = 0;
    for (int w = 0; w < n; w++)
      for (int b = 0; b < 4; b++) exp_bytes.push_back(words[w][8*b +: 8]);
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    chk(dreq_o == 1, "R2 request after start", dreq_o, 1);
    fork
      dma_run(n);
      initiator(4 * n, mode);
      if (glitch) glitch_done();
      if (midstart) late_start();
    join
    repeat (6) @(negedge clk);
    chk(dreq_o == 0 && ready_o == 0 && req_o == 0, "R8 idle after final word",
        {dreq_o, ready_o, req_o}, 0);
    chk(rx_count == 4 * n, "R7 byte count per burst", rx_count, 4 * n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dreq_o == 0 && ready_o == 0 && req_o == 0 && sdata_o == 0, "R1 reset state",
        {dreq_o, ready_o, req_o, sdata_o}, 0);
    rst = 0;
    repeat (2) @(negedge clk);

    words[0] = 32'h44332211;
    run_case(1, 0, 0, 0);

    words[0] = 32'hDEADBEEF; words[1] = 32'h01020304; words[2] = 32'h80FF7F00;
    run_case(3, 1, 1, 0);

    words[0] = 32'h000000FF; words[1] = 32'hA5C35A3C;
    run_case(2, 3, 0, 1);

    for (int i = 0; i < 5; i++) words[i] = 32'h9E3779B9 * (i + 1);
    run_case(5, 2, 1, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule